// File: doc/BRIEF.md
# Second-Pulse Synchronised Offset and Phase Update Register

This block holds the frequency-offset and starting-phase settings for two synthesizer channels, called upper (index 0) and lower (index 1). It applies them together on the rising edge of an external once-per-second timing pulse. Timed commands received during a second are staged. On the next pulse the staged values move into the active registers, and a one-cycle load request goes out for each channel whose values changed. A serial writer downstream uses that request to push the values to the synthesizers. A timed command that arrives too close to the pulse is held back until the pulse after that one.

Maintenance commands take a separate, immediate path. They overwrite the main frequency and offset, or the phase, of one channel at once, without waiting for the pulse. The active registers double as the "last command" readback. Until the first command arrives they hold the reset defaults: zero offset, zero phase and a parameterised main frequency. Out-of-range fields are clamped, and each clamp raises a one-cycle error flag. Command decoding and the serial transfer are handled outside this block.

Top module: `sec_pulse_update`

## Requirements
- R1: Offset and phase from timed commands do not reach the outputs before a pulse. They appear, together with the load request, in the third clock cycle after `pps_i` rises. The pulse passes through two synchroniser flops and an edge register first.
- R2: The dual command carries two signed 16-bit offsets in millihertz, clamped to ±32000, and two unsigned 16-bit phases in milliturns, clamped to 999. One offset and one phase go to the upper channel and the other pair to the lower channel.
- R3: The single-channel timed command targets the channel given by `chan_sel_i` (0 = upper, 1 = lower). It carries a signed 32-bit offset clamped to ±2,000,000,000 and a phase clamped to 999. If it arrives in the same cycle as a dual command, it takes precedence for the channel it targets.
- R4: The maintenance frequency command writes the selected channel's main frequency and its signed 16-bit offset into the active registers on the next clock edge. The frequency is clamped to 160,000,000 Hz and the offset to ±32000.
- R5: The maintenance phase command writes the selected channel's phase, clamped to 999, into the active register on the next clock edge.
- R6: After reset, both channels read offset 0, phase 0 and main frequency `DEF_FREQ`, and `load_o`, `late_o` and `range_err_o` are low.
- R7: A timed command is late if it arrives once `PERIOD_CYC - GUARD_CYC` or more cycles have passed since the last pulse. A late command is held for the pulse after the next one, and `late_o` is high for one cycle after it arrives.
- R8: `range_err_o` is high for one cycle after any accepted command in which a field was clamped, and low after a command in which no field was clamped.
- R9: One rising edge of `pps_i` gives exactly one update, however long the pulse stays high.
- R10: `load_o[c]` is high for exactly one cycle each time channel c's active values are replaced, whether by a pulse or by a maintenance command.
- R11: A pulse with nothing staged leaves the active values unchanged and raises no load request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pps_i | input | 1 | Once-per-second timing pulse, asynchronous |
| dual_cmd_i | input | 1 | Strobe for the dual timed command |
| dual_up_ofs_i | input | 16 | Upper channel offset, signed, mHz |
| dual_up_ph_i | input | 16 | Upper channel phase, milliturns |
| dual_lo_ofs_i | input | 16 | Lower channel offset, signed, mHz |
| dual_lo_ph_i | input | 16 | Lower channel phase, milliturns |
| chan_cmd_i | input | 1 | Strobe for the single-channel timed command |
| chan_sel_i | input | 1 | Target channel, 0 upper, 1 lower |
| chan_ofs_i | input | 32 | Offset, signed, mHz |
| chan_ph_i | input | 16 | Phase, milliturns |
| maint_freq_cmd_i | input | 1 | Strobe for the immediate frequency command |
| maint_ph_cmd_i | input | 1 | Strobe for the immediate phase command |
| maint_sel_i | input | 1 | Target channel for maintenance commands |
| maint_freq_i | input | 32 | Main frequency, Hz |
| maint_ofs_i | input | 16 | Offset, signed, mHz |
| maint_ph_i | input | 16 | Phase, milliturns |
| up_ofs_o | output | 32 | Upper channel active offset |
| up_ph_o | output | 16 | Upper channel active phase |
| up_freq_o | output | 32 | Upper channel active main frequency |
| lo_ofs_o | output | 32 | Lower channel active offset |
| lo_ph_o | output | 16 | Lower channel active phase |
| lo_freq_o | output | 32 | Lower channel active main frequency |
| load_o | output | 2 | Per-channel load request, bit 0 upper |
| late_o | output | 1 | Late timed command seen |
| range_err_o | output | 1 | Clamped field seen |

## Verification
The bench builds the block with `PERIOD_CYC` = 200 and `GUARD_CYC` = 20, so one "second" lasts 200 cycles and the guard window covers its last 20. At that scale, a command can be placed just after a pulse or inside the guard window. The deferral to the second pulse and the empty pulse that comes between can then both be observed within a short run. `DEF_FREQ` keeps its default, so the reset readback can be checked against a known frequency.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int OFS_W  = 32;
  localparam int PH_W   = 16;
  localparam int FREQ_W = 32;
  localparam int NCH    = 2;

  localparam logic [PH_W-1:0]          PH_MAX   = 16'd999;
  localparam logic signed [OFS_W-1:0]  DUAL_LIM = 32'sd32000;
  localparam logic signed [OFS_W-1:0]  CHAN_LIM = 32'sd2000000000;
  localparam logic [FREQ_W-1:0]        FREQ_MAX = 32'd160000000;

  typedef struct packed {
    logic [OFS_W-1:0] val;
    logic             err;
  } clamp_t;

  function automatic clamp_t clamp_s(input logic signed [OFS_W-1:0] v,
                                     input logic signed [OFS_W-1:0] lim);
    clamp_t r;
    r.err = 1'b0;
    r.val = v;
    if (v > lim) begin
      r.val = lim;
      r.err = 1'b1;
    end else if (v < -lim) begin
      r.val = -lim;
      r.err = 1'b1;
    end
    return r;
  endfunction

  function automatic clamp_t clamp_u(input logic [OFS_W-1:0] v,
                                     input logic [OFS_W-1:0] lim);
    clamp_t r;
    r.err = v > lim;
    r.val = r.err ? lim : v;
    return r;
  endfunction
endpackage

// File: rtl/sps_pulse_sync.sv
module sps_pulse_sync #(
  parameter int unsigned PERIOD_CYC = 50_000_000,
  parameter int unsigned GUARD_CYC  = 2_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pps_i,
  output logic tick_o,
  output logic late_win_o
);
  localparam int CNT_W = $clog2(PERIOD_CYC);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0] LATE_AT = CNT_W'(PERIOD_CYC - GUARD_CYC);

  logic [2:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], pps_i};
  end

  assign tick_o = sync_q[1] & ~sync_q[2];

  // cycles since last accepted pulse, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (tick_o)          cnt_q <= '0;
    else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign late_win_o = cnt_q >= LATE_AT;

  AST_ONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R9
  AST_TICK_CLEARS_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !late_win_o); // R7
endmodule

// File: rtl/sps_chan_bank.sv
module sps_chan_bank
  import sps_pkg::*;
#(
  parameter logic [FREQ_W-1:0] DEF_FREQ = 32'd100000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              st_we_i,
  input  logic              st_late_i,
  input  logic [OFS_W-1:0]  st_ofs_i,
  input  logic [PH_W-1:0]   st_ph_i,
  input  logic              im_freq_we_i,
  input  logic [FREQ_W-1:0] im_freq_i,
  input  logic [OFS_W-1:0]  im_ofs_i,
  input  logic              im_ph_we_i,
  input  logic [PH_W-1:0]   im_ph_i,
  output logic [OFS_W-1:0]  act_ofs_o,
  output logic [PH_W-1:0]   act_ph_o,
  output logic [FREQ_W-1:0] act_freq_o,
  output logic              load_o
);
  logic [OFS_W-1:0]  nxt_ofs_q, dfr_ofs_q, act_ofs_q;
  logic [PH_W-1:0]   nxt_ph_q, dfr_ph_q, act_ph_q;
  logic              nxt_vld_q, dfr_vld_q, load_q;
  logic [FREQ_W-1:0] act_freq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_ofs_q  <= '0;
      act_ph_q   <= '0;
      act_freq_q <= DEF_FREQ;
      nxt_ofs_q  <= '0;
      nxt_ph_q   <= '0;
      nxt_vld_q  <= 1'b0;
      dfr_ofs_q  <= '0;
      dfr_ph_q   <= '0;
      dfr_vld_q  <= 1'b0;
      load_q     <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (tick_i) begin
        if (nxt_vld_q) begin
          act_ofs_q <= nxt_ofs_q;
          act_ph_q  <= nxt_ph_q;
          load_q    <= 1'b1;
        end
        // deferred bank advances one pulse
        nxt_vld_q <= dfr_vld_q;
        nxt_ofs_q <= dfr_ofs_q;
        nxt_ph_q  <= dfr_ph_q;
        dfr_vld_q <= 1'b0;
      end
      if (st_we_i) begin
        if (st_late_i) begin
          dfr_ofs_q <= st_ofs_i;
          dfr_ph_q  <= st_ph_i;
          dfr_vld_q <= 1'b1;
        end else begin
          nxt_ofs_q <= st_ofs_i;
          nxt_ph_q  <= st_ph_i;
          nxt_vld_q <= 1'b1;
        end
      end
      // immediate path overrides the pulse transfer
      if (im_freq_we_i) begin
        act_freq_q <= im_freq_i;
        act_ofs_q  <= im_ofs_i;
        load_q     <= 1'b1;
      end
      if (im_ph_we_i) begin
        act_ph_q <= im_ph_i;
        load_q   <= 1'b1;
      end
    end
  end

  assign act_ofs_o  = act_ofs_q;
  assign act_ph_o   = act_ph_q;
  assign act_freq_o = act_freq_q;
  assign load_o     = load_q;

  AST_PH_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_ph_q <= PH_MAX); // R2
  AST_HOLD_BETWEEN_PULSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !im_freq_we_i && !im_ph_we_i) |=> ($stable(act_ofs_q) && $stable(act_ph_q))); // R1
  AST_LOAD_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(act_ofs_q) || !$stable(act_ph_q) || !$stable(act_freq_q)) |-> load_q); // R10
  AST_EMPTY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !nxt_vld_q && !im_freq_we_i && !im_ph_we_i) |=> !load_q); // R11
endmodule

// File: rtl/sec_pulse_update.sv
module sec_pulse_update
  import sps_pkg::*;
#(
  parameter int unsigned       PERIOD_CYC = 50_000_000,
  parameter int unsigned       GUARD_CYC  = 2_500_000,
  parameter logic [FREQ_W-1:0] DEF_FREQ   = 32'd100000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pps_i,
  input  logic              dual_cmd_i,
  input  logic [15:0]       dual_up_ofs_i,
  input  logic [PH_W-1:0]   dual_up_ph_i,
  input  logic [15:0]       dual_lo_ofs_i,
  input  logic [PH_W-1:0]   dual_lo_ph_i,
  input  logic              chan_cmd_i,
  input  logic              chan_sel_i,
  input  logic [OFS_W-1:0]  chan_ofs_i,
  input  logic [PH_W-1:0]   chan_ph_i,
  input  logic              maint_freq_cmd_i,
  input  logic              maint_ph_cmd_i,
  input  logic              maint_sel_i,
  input  logic [FREQ_W-1:0] maint_freq_i,
  input  logic [15:0]       maint_ofs_i,
  input  logic [PH_W-1:0]   maint_ph_i,
  output logic [OFS_W-1:0]  up_ofs_o,
  output logic [PH_W-1:0]   up_ph_o,
  output logic [FREQ_W-1:0] up_freq_o,
  output logic [OFS_W-1:0]  lo_ofs_o,
  output logic [PH_W-1:0]   lo_ph_o,
  output logic [FREQ_W-1:0] lo_freq_o,
  output logic [NCH-1:0]    load_o,
  output logic              late_o,
  output logic              range_err_o
);
  logic tick, late_win;

  sps_pulse_sync #(.PERIOD_CYC(PERIOD_CYC), .GUARD_CYC(GUARD_CYC)) u_sync (
    .clk_i, .rst_ni, .pps_i, .tick_o(tick), .late_win_o(late_win)
  );

  // clamp every field once
  clamp_t dual_ofs_c [NCH];
  clamp_t dual_ph_c  [NCH];
  clamp_t chan_ofs_c, chan_ph_c, m_freq_c, m_ofs_c, m_ph_c;

  assign dual_ofs_c[0] = clamp_s(OFS_W'(signed'(dual_up_ofs_i)), DUAL_LIM);
  assign dual_ofs_c[1] = clamp_s(OFS_W'(signed'(dual_lo_ofs_i)), DUAL_LIM);
  assign dual_ph_c[0]  = clamp_u(OFS_W'(dual_up_ph_i), OFS_W'(PH_MAX));
  assign dual_ph_c[1]  = clamp_u(OFS_W'(dual_lo_ph_i), OFS_W'(PH_MAX));
  assign chan_ofs_c    = clamp_s(chan_ofs_i, CHAN_LIM);
  assign chan_ph_c     = clamp_u(OFS_W'(chan_ph_i), OFS_W'(PH_MAX));
  assign m_freq_c      = clamp_u(maint_freq_i, FREQ_MAX);
  assign m_ofs_c       = clamp_s(OFS_W'(signed'(maint_ofs_i)), DUAL_LIM);
  assign m_ph_c        = clamp_u(OFS_W'(maint_ph_i), OFS_W'(PH_MAX));

  logic err_d;
  always_comb begin
    err_d = 1'b0;
    if (dual_cmd_i)
      err_d = dual_ofs_c[0].err | dual_ofs_c[1].err | dual_ph_c[0].err | dual_ph_c[1].err;
    if (chan_cmd_i)       err_d = err_d | chan_ofs_c.err | chan_ph_c.err;
    if (maint_freq_cmd_i) err_d = err_d | m_freq_c.err | m_ofs_c.err;
    if (maint_ph_cmd_i)   err_d = err_d | m_ph_c.err;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      late_o      <= 1'b0;
      range_err_o <= 1'b0;
    end else begin
      late_o      <= (dual_cmd_i | chan_cmd_i) & late_win;
      range_err_o <= err_d;
    end
  end

  logic [OFS_W-1:0]  act_ofs  [NCH];
  logic [PH_W-1:0]   act_ph   [NCH];
  logic [FREQ_W-1:0] act_freq [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              st_we;
    logic [OFS_W-1:0]  st_ofs;
    logic [PH_W-1:0]   st_ph;
    logic              chan_hit, maint_hit;

    assign chan_hit  = chan_cmd_i && (chan_sel_i == c[0]);
    assign maint_hit = maint_sel_i == c[0];

    // single-channel command wins over dual in the same cycle
    always_comb begin
      st_we  = dual_cmd_i | chan_hit;
      st_ofs = dual_ofs_c[c].val;
      st_ph  = dual_ph_c[c].val[PH_W-1:0];
      if (chan_hit) begin
        st_ofs = chan_ofs_c.val;
        st_ph  = chan_ph_c.val[PH_W-1:0];
      end
    end

    sps_chan_bank #(.DEF_FREQ(DEF_FREQ)) u_bank (
      .clk_i,
      .rst_ni,
      .tick_i       (tick),
      .st_we_i      (st_we),
      .st_late_i    (late_win),
      .st_ofs_i     (st_ofs),
      .st_ph_i      (st_ph),
      .im_freq_we_i (maint_freq_cmd_i & maint_hit),
      .im_freq_i    (m_freq_c.val),
      .im_ofs_i     (m_ofs_c.val),
      .im_ph_we_i   (maint_ph_cmd_i & maint_hit),
      .im_ph_i      (m_ph_c.val[PH_W-1:0]),
      .act_ofs_o    (act_ofs[c]),
      .act_ph_o     (act_ph[c]),
      .act_freq_o   (act_freq[c]),
      .load_o       (load_o[c])
    );
  end

  assign up_ofs_o  = act_ofs[0];
  assign up_ph_o   = act_ph[0];
  assign up_freq_o = act_freq[0];
  assign lo_ofs_o  = act_ofs[1];
  assign lo_ph_o   = act_ph[1];
  assign lo_freq_o = act_freq[1];

  AST_FREQ_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_freq_o <= FREQ_MAX) && (lo_freq_o <= FREQ_MAX)); // R4
  AST_UP_OFS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(up_ofs_o) <= CHAN_LIM) && ($signed(up_ofs_o) >= -CHAN_LIM)); // R3
  AST_LATE_ONLY_TIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dual_cmd_i && !chan_cmd_i) |=> !late_o); // R7
endmodule

// File: tb/tb_sec_pulse_update.sv
module tb_sec_pulse_update;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        pps = 0;
  logic        dual_cmd = 0, chan_cmd = 0, chan_sel = 0;
  logic [15:0] d_up_ofs = 0, d_up_ph = 0, d_lo_ofs = 0, d_lo_ph = 0;
  logic [31:0] c_ofs = 0;
  logic [15:0] c_ph = 0;
  logic        m_freq_cmd = 0, m_ph_cmd = 0, m_sel = 0;
  logic [31:0] m_freq = 0;
  logic [15:0] m_ofs = 0, m_ph = 0;
  logic [31:0] up_ofs, lo_ofs, up_freq, lo_freq;
  logic [15:0] up_ph, lo_ph;
  logic [1:0]  load;
  logic        late, rerr;

  int checks = 0, errors = 0;

  sec_pulse_update #(.PERIOD_CYC(200), .GUARD_CYC(20)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pps_i(pps),
    .dual_cmd_i(dual_cmd), .dual_up_ofs_i(d_up_ofs), .dual_up_ph_i(d_up_ph),
    .dual_lo_ofs_i(d_lo_ofs), .dual_lo_ph_i(d_lo_ph),
    .chan_cmd_i(chan_cmd), .chan_sel_i(chan_sel), .chan_ofs_i(c_ofs), .chan_ph_i(c_ph),
    .maint_freq_cmd_i(m_freq_cmd), .maint_ph_cmd_i(m_ph_cmd), .maint_sel_i(m_sel),
    .maint_freq_i(m_freq), .maint_ofs_i(m_ofs), .maint_ph_i(m_ph),
    .up_ofs_o(up_ofs), .up_ph_o(up_ph), .up_freq_o(up_freq),
    .lo_ofs_o(lo_ofs), .lo_ph_o(lo_ph), .lo_freq_o(lo_freq),
    .load_o(load), .late_o(late), .range_err_o(rerr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%h) expected %0d (0x%h)", req, what, $signed(act), act, $signed(exp), exp);
    end
  endtask

  // pulse rises; returns at the sample point after the second edge
  task automatic pulse_rise();
    @(negedge clk) pps = 1;
    repeat (2) @(negedge clk);
  endtask
  task automatic pulse_apply();
    @(negedge clk);
  endtask
  task automatic pulse_fall();
    repeat (2) @(negedge clk);
    pps = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_dual(input logic [15:0] uo, up, lo, lp);
    @(negedge clk);
    d_up_ofs = uo; d_up_ph = up; d_lo_ofs = lo; d_lo_ph = lp; dual_cmd = 1;
    @(negedge clk) dual_cmd = 0;
  endtask

  task automatic send_chan(input logic sel, input logic [31:0] o, input logic [15:0] p);
    @(negedge clk);
    chan_sel = sel; c_ofs = o; c_ph = p; chan_cmd = 1;
    @(negedge clk) chan_cmd = 0;
  endtask

  task automatic t_reset();
    chk("R6", "up_ofs", up_ofs, 0);
    chk("R6", "lo_ph", {16'd0, lo_ph}, 0);
    chk("R6", "up_freq", up_freq, 32'd100000000);
    chk("R6", "lo_freq", lo_freq, 32'd100000000);
    chk("R6", "flags", {28'd0, load, late, rerr}, 0);
  endtask

  task automatic t_dual_pulse();
    send_dual(16'd1234, 16'd250, 16'hFF9C, 16'd999); // lower offset -100
    chk("R8", "no clamp err", {31'd0, rerr}, 0);
    chk("R7", "early not late", {31'd0, late}, 0);
    chk("R1", "staged hidden up", up_ofs, 0);
    pulse_rise();
    chk("R1", "before pulse edge", up_ofs, 0);
    chk("R10", "no load yet", {30'd0, load}, 0);
    pulse_apply();
    chk("R2", "up_ofs", up_ofs, 32'd1234);
    chk("R2", "up_ph", {16'd0, up_ph}, 250);
    chk("R2", "lo_ofs", lo_ofs, 32'hFFFFFF9C);
    chk("R2", "lo_ph", {16'd0, lo_ph}, 999);
    chk("R10", "load both", {30'd0, load}, 2'b11);
    @(negedge clk);
    chk("R10", "load one cycle", {30'd0, load}, 0);
    pulse_fall();
  endtask

  task automatic t_dual_clamp();
    send_dual(16'd32767, 16'd1000, 16'h8000, 16'd0);
    chk("R8", "clamp err", {31'd0, rerr}, 1);
    @(negedge clk);
    chk("R8", "err one cycle", {31'd0, rerr}, 0);
    pulse_rise(); pulse_apply();
    chk("R2", "up_ofs clamp", up_ofs, 32'd32000);
    chk("R2", "up_ph clamp", {16'd0, up_ph}, 999);
    chk("R2", "lo_ofs clamp", lo_ofs, -32'sd32000);
    pulse_fall();
  endtask

  task automatic t_chan();
    send_chan(1'b1, 32'h80000000, 16'd17);
    chk("R8", "chan clamp err", {31'd0, rerr}, 1);
    // same-cycle dual and single: single wins for upper
    @(negedge clk);
    d_up_ofs = 16'd5; d_up_ph = 16'd5; d_lo_ofs = 16'd6; d_lo_ph = 16'd6; dual_cmd = 1;
    chan_sel = 0; c_ofs = 32'd1999999999; c_ph = 16'd42; chan_cmd = 1;
    @(negedge clk) dual_cmd = 0; chan_cmd = 0;
    pulse_rise(); pulse_apply();
    chk("R3", "up priority ofs", up_ofs, 32'd1999999999);
    chk("R3", "up priority ph", {16'd0, up_ph}, 42);
    chk("R3", "lo from dual", lo_ofs, 32'd6);
    pulse_fall();
    send_chan(1'b1, 32'h80000000, 16'd17);
    pulse_rise(); pulse_apply();
    chk("R3", "lo ofs clamp", lo_ofs, -32'sd2000000000);
    chk("R3", "lo ph", {16'd0, lo_ph}, 17);
    chk("R10", "load lower only", {30'd0, load}, 2'b10);
    pulse_fall();
  endtask

  task automatic t_maint();
    @(negedge clk);
    m_sel = 0; m_freq = 32'd200000000; m_ofs = 16'hFFFF; m_freq_cmd = 1;
    @(negedge clk) m_freq_cmd = 0;
    chk("R4", "freq clamp", up_freq, 32'd160000000);
    chk("R4", "ofs immediate", up_ofs, 32'hFFFFFFFF);
    chk("R8", "freq clamp err", {31'd0, rerr}, 1);
    chk("R10", "load upper", {30'd0, load}, 2'b01);
    chk("R4", "lower untouched", lo_freq, 32'd100000000);
    m_sel = 1; m_ph = 16'd333; m_ph_cmd = 1;
    @(negedge clk) m_ph_cmd = 0;
    chk("R5", "lo_ph immediate", {16'd0, lo_ph}, 333);
    chk("R10", "load lower", {30'd0, load}, 2'b10);
    chk("R8", "no err", {31'd0, rerr}, 0);
    m_ph = 16'd4000; m_ph_cmd = 1;
    @(negedge clk) m_ph_cmd = 0;
    chk("R5", "lo_ph clamp", {16'd0, lo_ph}, 999);
  endtask

  task automatic t_empty();
    logic [31:0] o;
    o = up_ofs;
    pulse_rise(); pulse_apply();
    chk("R11", "no load", {30'd0, load}, 0);
    chk("R11", "up_ofs kept", up_ofs, o);
    pulse_fall();
  endtask

  task automatic t_late();
    pulse_rise(); pulse_apply(); pulse_fall();
    repeat (180) @(negedge clk);
    send_chan(1'b0, 32'd777, 16'd5);
    chk("R7", "late flag", {31'd0, late}, 1);
    pulse_rise(); pulse_apply();
    chk("R7", "held past pulse", {30'd0, load}, 0);
    chk("R7", "up_ofs unchanged", up_ofs == 32'd777 ? 32'd1 : 32'd0, 0);
    pulse_fall();
    pulse_rise(); pulse_apply();
    chk("R7", "applied next pulse", up_ofs, 32'd777);
    chk("R7", "phase next pulse", {16'd0, up_ph}, 5);
    pulse_fall();
  endtask

  task automatic t_long();
    int n = 0;
    send_dual(16'd11, 16'd12, 16'd13, 16'd14);
    @(negedge clk) pps = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (load[0]) n++;
    end
    pps = 0;
    repeat (4) @(negedge clk);
    chk("R9", "single update", n, 1);
    chk("R9", "value", up_ofs, 32'd11);
  endtask

  initial begin
    #50000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_dual_pulse();
    t_dual_clamp();
    t_chan();
    t_maint();
    t_empty();
    t_late();
    t_long();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule